// File: doc/BRIEF.md
# Divider-Based Sine Excitation Generator

This block produces the digital sine wave that drives the primary winding of a displacement transformer. One carrier period is held as a table of signed samples. The generator steps through that table at a rate set by dividing the system clock by an integer. A 4-bit frequency code chooses the divider from a second, computed table. With the default 16 MHz clock, the carrier frequencies run in equal steps from 10 kHz (code 0) to 20 kHz (code 15).

Each new sample comes with a one-clock valid strobe. The block also flags the instants at which it issues the carrier's positive and negative crests. Because the generator creates the carrier itself, a downstream synchronous demodulator can use these flags to sample the modulated secondary signal without any peak detection. The frequency code may change at any time. The generator holds a new code back until the sample table wraps, so every carrier period it emits is whole.

Top module: `sine_excite_gen`

## Requirements
- R1: Synchronous active-high reset clears `sample_o` to 0, drops all three strobes, sets the table position to 0 and makes code 0 active whatever `freq_sel_i` holds. The first valid strobe after reset arrives 25 clocks after reset is released, and it carries position 0.
- R2: While code k is active, successive valid strobes are exactly D(k) clocks apart. D(k) = round(16e6 / (64 · f_k)) with f_k = 10000 + k·10000/15 Hz, and halves round up, so D(0)=25 and D(15)=13.
- R3: The sample issued at table position i is within 4 LSB of round(2047 · sin(2πi/64)). Positions 0 and 32 give exactly 0, position 16 gives +2047 and position 48 gives −2047. Samples are 12-bit two's complement.
- R4: `peak_pos_o` pulses together with the valid strobe of position 16 and at no other time. `peak_neg_o` does the same for position 48.
- R5: A change on `freq_sel_i` takes effect only when position 63 is issued. The interval that ends with the next position-0 strobe already uses the new divider, and every earlier interval keeps the old one. Only the code present when position 63 is issued counts.
- R6: Positions advance by one per valid strobe and wrap from 63 to 0. The sample sequence repeats each period, and the sample at position i+32 is the negative of the sample at position i.
- R7: Each strobe is high for exactly one clock.
- R8: `sample_o` holds its value in every cycle without a valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel_i | input | 4 | Requested carrier frequency code |
| sample_o | output | 12 | Current sine sample, two's complement |
| sample_vld_o | output | 1 | One-clock strobe marking a new sample |
| peak_pos_o | output | 1 | Strobe at the positive carrier crest |
| peak_neg_o | output | 1 | Strobe at the negative carrier crest |

## Verification
Every output is registered once after the divider's terminal count. So a sample, its valid strobe and any crest flag all appear in the cycle after the count expires: D(k) clocks after the previous strobe, or 25 clocks after reset is released. The bench samples on falling edges and counts the falling edges between strobes. It keeps its own model of the table position and the active code, and updates the active code only when it sees position 63 issued. This places the expected interval change on the strobe for position 0. Code changes are driven just after a strobe is observed, so their position against the wrap edge is never in doubt.

// File: rtl/excite_pkg.sv
package excite_pkg;

   // Clock divider for frequency code k: frequencies are spaced linearly
   // between f_lo and f_hi over 'steps' intervals, result rounded half-up.
   function automatic int unsigned div_for_code(
      input longint unsigned clk_hz,
      input longint unsigned n_samp,
      input longint unsigned f_lo,
      input longint unsigned f_hi,
      input longint unsigned steps,
      input longint unsigned k);
      longint unsigned num;
      num = f_lo * steps + k * (f_hi - f_lo);
      return int'((2 * clk_hz * steps + n_samp * num) / (2 * n_samp * num));
   endfunction

   // Integer sine approximation, rational form over a half period,
   // odd-symmetric about the half-period point.
   function automatic int sine_point(input int idx, input int n_samp, input int amp);
      int half, j, t, den, v;
      half = n_samp / 2;
      j    = idx % half;
      t    = j * (half - j);
      den  = 5 * half * half - 4 * t;
      v    = (amp * 16 * t + den / 2) / den;
      return (idx % n_samp >= half) ? -v : v;
   endfunction

endpackage

// File: rtl/excite_div_rom.sv
module excite_div_rom #(
   parameter int unsigned CLK_HZ    = 16_000_000,
   parameter int unsigned N_SAMPLES = 64,
   parameter int unsigned F_MIN_HZ  = 10_000,
   parameter int unsigned F_MAX_HZ  = 20_000,
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned DIV_W     = 5
) (
   input  logic [SEL_W-1:0] code_i,
   output logic [DIV_W-1:0] div_o
);
   localparam int unsigned N_CODES = 2 ** SEL_W;

   logic [DIV_W-1:0] div_tab [N_CODES];

   for (genvar k = 0; k < N_CODES; k++) begin : g_code
      assign div_tab[k] = DIV_W'(excite_pkg::div_for_code(
         CLK_HZ, N_SAMPLES, F_MIN_HZ, F_MAX_HZ, N_CODES - 1, k));
   end

   assign div_o = div_tab[code_i];
endmodule

// File: rtl/excite_sine_rom.sv
module excite_sine_rom #(
   parameter int unsigned N_SAMPLES    = 64,
   parameter int unsigned SAMPLE_W     = 12,
   parameter bit          QUARTER_WAVE = 1'b1
) (
   input  logic [$clog2(N_SAMPLES)-1:0] idx_i,
   output logic signed [SAMPLE_W-1:0]   val_o
);
   localparam int unsigned IDX_W = $clog2(N_SAMPLES);
   localparam int          AMP   = 2 ** (SAMPLE_W - 1) - 1;
   localparam int unsigned QTR   = N_SAMPLES / 4;

   if (QUARTER_WAVE) begin : g_quarter
      localparam logic [IDX_W-2:0] QTR_IDX = (IDX_W-1)'(QTR);
      logic signed [SAMPLE_W-1:0] q_tab [QTR + 1];
      logic [IDX_W-2:0]           q_pos;
      logic [IDX_W-2:0]           q_fold;
      logic signed [SAMPLE_W-1:0] mag;

      for (genvar i = 0; i <= QTR; i++) begin : g_ent
         assign q_tab[i] = SAMPLE_W'(excite_pkg::sine_point(i, N_SAMPLES, AMP));
      end

      assign q_pos  = idx_i[IDX_W-2:0];
      assign q_fold = (q_pos > QTR_IDX) ? ((~q_pos) + 1'b1) : q_pos;
      assign mag    = q_tab[q_fold];
      assign val_o  = idx_i[IDX_W-1] ? -mag : mag;
   end else begin : g_full
      logic signed [SAMPLE_W-1:0] f_tab [N_SAMPLES];

      for (genvar i = 0; i < N_SAMPLES; i++) begin : g_ent
         assign f_tab[i] = SAMPLE_W'(excite_pkg::sine_point(i, N_SAMPLES, AMP));
      end

      assign val_o = f_tab[idx_i];
   end
endmodule

// File: rtl/excite_rate_timer.sv
module excite_rate_timer #(
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   // A divider change only lands on a tick edge, where the count restarts.
   assign tick_o = (cnt_q >= div_i - 1'b1);

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sine_excite_gen.sv
module sine_excite_gen #(
   parameter int unsigned CLK_HZ       = 16_000_000,
   parameter int unsigned N_SAMPLES    = 64,
   parameter int unsigned SAMPLE_W     = 12,
   parameter int unsigned SEL_W        = 4,
   parameter int unsigned F_MIN_HZ     = 10_000,
   parameter int unsigned F_MAX_HZ     = 20_000,
   parameter bit          QUARTER_WAVE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [SEL_W-1:0]           freq_sel_i,
   output logic signed [SAMPLE_W-1:0] sample_o,
   output logic                       sample_vld_o,
   output logic                       peak_pos_o,
   output logic                       peak_neg_o
);
   localparam int unsigned IDX_W   = $clog2(N_SAMPLES);
   localparam int unsigned N_CODES = 2 ** SEL_W;
   localparam int unsigned DIV_HI  = excite_pkg::div_for_code(
      CLK_HZ, N_SAMPLES, F_MIN_HZ, F_MAX_HZ, N_CODES - 1, 0);
   localparam int unsigned DIV_LO  = excite_pkg::div_for_code(
      CLK_HZ, N_SAMPLES, F_MIN_HZ, F_MAX_HZ, N_CODES - 1, N_CODES - 1);
   localparam int unsigned DIV_W   = $clog2(DIV_HI + 1);
   localparam logic [IDX_W-1:0] POS_IDX  = IDX_W'(N_SAMPLES / 4);
   localparam logic [IDX_W-1:0] NEG_IDX  = IDX_W'(3 * N_SAMPLES / 4);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SAMPLES - 1);

   if (N_SAMPLES < 8 || (N_SAMPLES & (N_SAMPLES - 1)) != 0) begin : g_bad_depth
      $error("N_SAMPLES must be a power of two of at least 8");
   end
   if (F_MAX_HZ <= F_MIN_HZ) begin : g_bad_span
      $error("F_MAX_HZ must exceed F_MIN_HZ");
   end
   if (DIV_LO < 2) begin : g_bad_div
      $error("clock too slow for the highest frequency code");
   end
   if (SAMPLE_W < 4) begin : g_bad_width
      $error("SAMPLE_W too narrow");
   end

   logic [SEL_W-1:0]           code_q;
   logic [IDX_W-1:0]           idx_q;
   logic [DIV_W-1:0]           div_cur;
   logic                       tick;
   logic signed [SAMPLE_W-1:0] rom_val;

   excite_div_rom #(
      .CLK_HZ(CLK_HZ), .N_SAMPLES(N_SAMPLES), .F_MIN_HZ(F_MIN_HZ),
      .F_MAX_HZ(F_MAX_HZ), .SEL_W(SEL_W), .DIV_W(DIV_W)
   ) u_div_rom (
      .code_i(code_q),
      .div_o (div_cur)
   );

   excite_rate_timer #(.DIV_W(DIV_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .div_i (div_cur),
      .tick_o(tick)
   );

   excite_sine_rom #(
      .N_SAMPLES(N_SAMPLES), .SAMPLE_W(SAMPLE_W), .QUARTER_WAVE(QUARTER_WAVE)
   ) u_sine_rom (
      .idx_i(idx_q),
      .val_o(rom_val)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q        <= '0;
         code_q       <= '0;
         sample_o     <= '0;
         sample_vld_o <= 1'b0;
         peak_pos_o   <= 1'b0;
         peak_neg_o   <= 1'b0;
      end else begin
         sample_vld_o <= tick;
         peak_pos_o   <= tick && (idx_q == POS_IDX);
         peak_neg_o   <= tick && (idx_q == NEG_IDX);
         if (tick) begin
            sample_o <= rom_val;
            idx_q    <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) code_q <= freq_sel_i;
         end
      end
   end
endmodule

// File: rtl/excite_chk.sv
module excite_chk #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned DIV_LO   = 13,
   parameter int unsigned DIV_HI   = 25
) (
   input logic                       clk,
   input logic                       rst,
   input logic signed [SAMPLE_W-1:0] sample_o,
   input logic                       sample_vld_o,
   input logic                       peak_pos_o,
   input logic                       peak_neg_o,
   input logic [SEL_W-1:0]           code_q,
   input logic [IDX_W-1:0]           idx_q
);
   localparam logic signed [SAMPLE_W-1:0] AMP = SAMPLE_W'(2 ** (SAMPLE_W - 1) - 1);

   logic        past_ok;
   logic        armed;
   logic [15:0] gap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         past_ok <= 1'b0;
         armed   <= 1'b0;
         gap_q   <= '0;
      end else begin
         past_ok <= 1'b1;
         if (sample_vld_o) begin
            armed <= 1'b1;
            gap_q <= 16'd1;
         end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   p_peaks_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
      (peak_pos_o || peak_neg_o) |-> sample_vld_o);
   p_pos_crest_r3: assert property (@(posedge clk) disable iff (rst)
      peak_pos_o |-> (sample_o == AMP));
   p_neg_crest_r3: assert property (@(posedge clk) disable iff (rst)
      peak_neg_o |-> (sample_o == -AMP));
   p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      sample_vld_o |=> !sample_vld_o);
   p_hold_sample_r8: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !sample_vld_o) |-> $stable(sample_o));
   p_gap_bounds_r2: assert property (@(posedge clk) disable iff (rst)
      (armed && sample_vld_o) |-> (gap_q >= 16'(DIV_LO) && gap_q <= 16'(DIV_HI)));
   p_code_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$stable(code_q)) |-> (idx_q == '0));
endmodule

bind sine_excite_gen excite_chk #(
   .SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W), .IDX_W(IDX_W),
   .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)
) i_excite_chk (
   .clk         (clk),
   .rst         (rst),
   .sample_o    (sample_o),
   .sample_vld_o(sample_vld_o),
   .peak_pos_o  (peak_pos_o),
   .peak_neg_o  (peak_neg_o),
   .code_q      (code_q),
   .idx_q       (idx_q)
);

// File: tb/test_sine_excite_gen.sv
`timescale 1ns/1ps
module test_sine_excite_gen;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [3:0]        sel_drv = 4'd0;
   logic signed [11:0] sample;
   logic              vld, ppos, pneg;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   int act_code = 0;
   int exp_idx  = 0;
   int last_smp = 0;
   int hist [64];

   always #2 clk = ~clk;

   sine_excite_gen i_sine_excite_gen (
      .clk(clk), .rst(rst), .freq_sel_i(sel_drv),
      .sample_o(sample), .sample_vld_o(vld),
      .peak_pos_o(ppos), .peak_neg_o(pneg)
   );

   function automatic int exp_div(input int k);
      real f;
      f = 10000.0 + k * 10000.0 / 15.0;
      return $rtoi(16.0e6 / (64.0 * f) + 0.5);
   endfunction

   function automatic int exp_sine(input int i);
      real s;
      s = 2047.0 * $sin(2.0 * 3.14159265358979 * i / 64.0);
      return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      act_code = 0;
      exp_idx  = 0;
      last_smp = 0;
   endtask

   // Wait for n samples, checking interval, hold, value and crest flags.
   task automatic run_samples(input int n);
      for (int s = 0; s < n; s++) begin
         int gap = 0;
         bit hold_bad = 0;
         int ev;
         do begin
            @(negedge clk);
            gap++;
            if (!vld && sample != last_smp) hold_bad = 1;
         end while (!vld && gap < 200);
         check(gap == exp_div(act_code), "R2 interval", gap, exp_div(act_code));
         check(!hold_bad, "R8 hold", sample, last_smp);
         ev = exp_sine(exp_idx);
         if (exp_idx % 16 == 0)
            check(sample == ev, "R3 exact point", sample, ev);
         else
            check(sample - ev <= 4 && ev - sample <= 4, "R3 value", sample, ev);
         check(ppos == (exp_idx == 16), "R4 pos crest", ppos, exp_idx == 16);
         check(pneg == (exp_idx == 48), "R4 neg crest", pneg, exp_idx == 48);
         hist[exp_idx] = sample;
         last_smp = sample;
         if (exp_idx == 63) act_code = sel_drv;
         exp_idx = (exp_idx + 1) % 64;
      end
   endtask

   task automatic t_reset_state();
      rst = 1'b1;
      sel_drv = 4'd6;
      repeat (4) @(negedge clk);
      check(sample == 0, "R1 reset sample", sample, 0);
      check(!vld && !ppos && !pneg, "R1 reset strobes", {vld, ppos, pneg}, 0);
      rst = 1'b0;
      model_reset();
      run_samples(1);
      check(exp_div(0) == 25, "R1 code 0 after reset", exp_div(0), 25);
   endtask

   task automatic t_slow_period();
      run_samples(63);
      sel_drv = 4'd0;
      run_samples(64);
   endtask

   task automatic t_fast_switch();
      sel_drv = 4'd15;
      run_samples(64);
      check(act_code == 15 && exp_div(15) == 13, "R5 fast code applied", exp_div(act_code), 13);
      run_samples(64);
   endtask

   task automatic t_mid_changes();
      run_samples(20);
      sel_drv = 4'd7;
      run_samples(20);
      sel_drv = 4'd3;
      run_samples(24);
      check(act_code == 3, "R5 last code wins", act_code, 3);
      run_samples(10);
      sel_drv = 4'd11;
      run_samples(54);
   endtask

   task automatic t_symmetry();
      int first [64];
      run_samples(64);
      for (int i = 0; i < 64; i++) first[i] = hist[i];
      for (int i = 0; i < 32; i++)
         check(first[i + 32] == -first[i], "R6 half-wave symmetry", first[i + 32], -first[i]);
      run_samples(64);
      for (int i = 0; i < 64; i += 8)
         check(hist[i] == first[i], "R6 period repeats", hist[i], first[i]);
   endtask

   task automatic t_reset_midway();
      sel_drv = 4'd9;
      run_samples(30);
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(sample == 0 && !vld, "R1 midway reset", sample, 0);
      rst = 1'b0;
      model_reset();
      run_samples(64);
      check(act_code == 9, "R5 code after reset wrap", act_code, 9);
      run_samples(16);
   endtask

   initial begin
      t_reset_state();
      t_slow_period();
      t_fast_switch();
      t_mid_changes();
      t_symmetry();
      t_reset_midway();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule